// File: doc/BRIEF.md
# CBC Iterative Block Cipher Engine

This block encrypts a stream of fixed-width data blocks in cipher block chaining order. Each plaintext block is first combined by XOR with a chaining value: the initialisation vector for the first block of a message, or the ciphertext produced just before it for every later block. The combined block then passes through an iterative cipher datapath, and the result is emitted as the ciphertext. That ciphertext also becomes the next chaining value.

The datapath holds one state register behind a multiplexer. The multiplexer takes either a freshly accepted block or the output of the round logic. The sequence is an initial key addition, then a parameterised number of rounds, then a final key addition. A parameter `UNROLL` places that many round instances in series, so that many rounds complete in each clock. Round keys come from an external read port addressed by key index, with one key lane for each unrolled round.

Because every block depends on the previous ciphertext, only one block is in flight at a time. The upstream producer sees `in_ready` drop for the whole computation.

Top module: `cbc_engine`

## Requirements
- R1: When a block is accepted with `in_sop` = 1, its ciphertext equals E(`in_data` XOR `in_iv`).
- R2: When a block is accepted with `in_sop` = 0, its ciphertext equals E(`in_data` XOR C), where C is the most recent ciphertext emitted.
- R3: E(x) is computed as follows. Start with s = x XOR K0. Then, for i = 1 to ROUNDS in increasing order, set s = rotl(s + Ki, ROT) XOR Ki, where + is addition modulo 2^BLK_W and rotl rotates left. The result is s XOR K(ROUNDS+1).
- R4: `key_idx` reads 0 while idle. In the cycle after acceptance it reads 1, and it then advances by UNROLL each cycle through the round phase. It reads ROUNDS+1 in the final-transform cycle. Lane j of `key_data` (bits j*BLK_W upward) must carry key number `key_idx`+j, and lane 0 is the only lane used outside the round phase.
- R5: `in_ready` is 1 after reset. It goes to 0 in the cycle after a block is accepted and stays 0 until the cycle in which `out_valid` is 1, when it is 1 again.
- R6: `out_valid` is a single-cycle pulse. It is 1 in the cycle following the (ROUNDS/UNROLL + 1)th rising edge after the accepting edge. ROUNDS must be a multiple of UNROLL, and UNROLL must lie between 1 and 5.
- R7: `out_data` holds the last ciphertext unchanged until the next `out_valid` pulse.
- R8: Activity on `in_valid`, `in_data`, `in_sop` and `in_iv` while `in_ready` is 0 has no effect: no extra output is produced, and neither the current result nor the chaining value changes.
- R9: A synchronous active-high `rst` clears the state, the round counter and the chaining value, and abandons any block in flight. After reset, `out_valid` = 0, `out_data` = 0, `in_ready` = 1 and `key_idx` = 0. A first block without `in_sop` therefore chains with zero.
- R10: `in_iv` is ignored when `in_sop` = 0. A block with `in_sop` = 1 in the middle of a stream restarts chaining from the new IV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Engine idle and able to take a block |
| in_sop | input | 1 | Block begins a new message; use `in_iv` as the chaining value |
| in_iv | input | BLK_W | Initialisation vector, sampled only with `in_sop` |
| in_data | input | BLK_W | Plaintext block |
| key_idx | output | $clog2(ROUNDS+2) | Index of the round key wanted on lane 0 |
| key_data | input | UNROLL*BLK_W | Round keys `key_idx` .. `key_idx`+UNROLL-1, lane 0 in the low bits |
| out_valid | output | 1 | Ciphertext pulse |
| out_data | output | BLK_W | Ciphertext, held between pulses |

## Verification
The hardest situation to reach is one where the input handshake misbehaves while a block is in flight. In that case the design must ignore new plaintext, a fresh start-of-message flag and a changed IV, and still leave the chaining value intact for the following block. The stimulus covers this by holding `in_valid` high during the busy window and scrambling `in_data`, `in_sop` and `in_iv` on every cycle. It then releases `in_valid` in the very cycle the ciphertext appears, which is the only cycle in which a stray request could be taken. A follow-up block without a start flag then shows whether the chain survived. A second case applies reset in the middle of a block and then sends a chained block, which shows that both the abandoned work and the old chaining value are gone.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ROUND = 2'd1,
    PH_FINAL = 2'd2
  } phase_e;
endpackage

// File: rtl/cbc_round.sv
// One stand-in cipher round: modular key add, fixed left rotation, key XOR.
module cbc_round #(
  parameter int W   = 64,
  parameter int ROT = 7
) (
  input  logic [W-1:0] blk_in,
  input  logic [W-1:0] rkey,
  output logic [W-1:0] blk_out
);
  logic [W-1:0] sum;

  always_comb begin
    sum     = blk_in + rkey;
    blk_out = {sum[W-ROT-1:0], sum[W-1:W-ROT]} ^ rkey;
  end
endmodule

// File: rtl/cbc_round_stack.sv
// UNROLL rounds in series; lane g of the key bus feeds round g.
module cbc_round_stack #(
  parameter int W      = 64,
  parameter int UNROLL = 2,
  parameter int ROT    = 7
) (
  input  logic [W-1:0]        din,
  input  logic [UNROLL*W-1:0] keys,
  output logic [W-1:0]        dout
);
  logic [W-1:0] stage [0:UNROLL];

  assign stage[0] = din;

  for (genvar g = 0; g < UNROLL; g++) begin : g_rnd
    cbc_round #(.W(W), .ROT(ROT)) u_round (
      .blk_in  (stage[g]),
      .rkey    (keys[g*W +: W]),
      .blk_out (stage[g+1])
    );
  end

  assign dout = stage[UNROLL];
endmodule

// File: rtl/cbc_seq.sv
// Phase and key-index sequencer: idle -> rounds -> final -> idle.
module cbc_seq
  import cbc_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int UNROLL = 2,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output phase_e           phase,
  output logic [IDX_W-1:0] key_idx
);
  localparam int LAST_BASE = ROUNDS - UNROLL + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      key_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_ROUND;
            key_idx <= IDX_W'(1);
          end
        end
        PH_ROUND: begin
          if (key_idx == IDX_W'(LAST_BASE)) begin
            phase   <= PH_FINAL;
            key_idx <= IDX_W'(ROUNDS + 1);
          end else begin
            key_idx <= key_idx + IDX_W'(UNROLL);
          end
        end
        PH_FINAL: begin
          phase   <= PH_IDLE;
          key_idx <= '0;
        end
        default: begin
          phase   <= PH_IDLE;
          key_idx <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cbc_state.sv
// State register behind the load / feedback multiplexer.
module cbc_state #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         advance,
  input  logic [W-1:0] fresh,
  input  logic [W-1:0] key0,
  input  logic [W-1:0] fed_back,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)          state <= '0;
    else if (load)    state <= fresh ^ key0;
    else if (advance) state <= fed_back;
  end
endmodule

// File: rtl/cbc_engine.sv
module cbc_engine
  import cbc_pkg::*;
#(
  parameter int BLK_W  = 64,
  parameter int ROUNDS = 8,
  parameter int UNROLL = 2,
  parameter int ROT    = 7,
  localparam int IDX_W = $clog2(ROUNDS + 2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sop,
  input  logic [BLK_W-1:0]        in_iv,
  input  logic [BLK_W-1:0]        in_data,
  output logic [IDX_W-1:0]        key_idx,
  input  logic [UNROLL*BLK_W-1:0] key_data,
  output logic                    out_valid,
  output logic [BLK_W-1:0]        out_data
);
  phase_e           phase;
  logic             accept;
  logic [BLK_W-1:0] chain_q;
  logic [BLK_W-1:0] chain_sel;
  logic [BLK_W-1:0] lane0;
  logic [BLK_W-1:0] state;
  logic [BLK_W-1:0] rounds_out;

  assign in_ready  = (phase == PH_IDLE);
  assign accept    = in_valid && in_ready;
  assign chain_sel = in_sop ? in_iv : chain_q;
  assign lane0     = key_data[BLK_W-1:0];

  cbc_seq #(.ROUNDS(ROUNDS), .UNROLL(UNROLL), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .phase   (phase),
    .key_idx (key_idx)
  );

  cbc_state #(.W(BLK_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .advance  (phase == PH_ROUND),
    .fresh    (in_data ^ chain_sel),
    .key0     (lane0),
    .fed_back (rounds_out),
    .state    (state)
  );

  cbc_round_stack #(.W(BLK_W), .UNROLL(UNROLL), .ROT(ROT)) u_stack (
    .din  (state),
    .keys (key_data),
    .dout (rounds_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      chain_q   <= '0;
    end else begin
      out_valid <= (phase == PH_FINAL);
      if (phase == PH_FINAL) begin
        out_data <= state ^ lane0;
        chain_q  <= state ^ lane0;
      end
    end
  end
endmodule

// File: rtl/cbc_engine_chk.sv
module cbc_engine_chk #(
  parameter int W      = 64,
  parameter int ROUNDS = 8,
  parameter int UNROLL = 2,
  parameter int IDX_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] key_idx,
  input logic             out_valid,
  input logic [W-1:0]     out_data
);
  localparam int LAT = ROUNDS / UNROLL + 1;

  logic        armed;
  logic [15:0] cnt;
  logic        past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (in_valid && in_ready) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (out_valid) begin
        armed <= 1'b0;
      end else if (armed) begin
        cnt <= cnt + 16'd1;
      end
    end
  end

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r5_ready_with_output: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (armed && cnt == 16'(LAT)));

  a_r4_first_round_key: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (key_idx == IDX_W'(1)));

  a_r4_key_range: assert property (@(posedge clk) disable iff (rst)
    key_idx <= IDX_W'(ROUNDS + 1));

  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !out_valid) |-> $stable(out_data));
endmodule

bind cbc_engine cbc_engine_chk #(
  .W(BLK_W), .ROUNDS(ROUNDS), .UNROLL(UNROLL), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .key_idx(key_idx), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cbc_engine_tb.sv
`timescale 1ns/1ps
module cbc_engine_tb;
  localparam int W      = 64;
  localparam int ROUNDS = 8;
  localparam int UNROLL = 2;
  localparam int ROT    = 7;
  localparam int IDX_W  = $clog2(ROUNDS + 2);
  localparam int LAT    = ROUNDS / UNROLL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_sop = 1'b0;
  logic [W-1:0] in_iv = '0, in_data = '0;
  logic [IDX_W-1:0] key_idx;
  logic [UNROLL*W-1:0] key_data;
  logic out_valid;
  logic [W-1:0] out_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cbc_engine #(.BLK_W(W), .ROUNDS(ROUNDS), .UNROLL(UNROLL), .ROT(ROT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_iv(in_iv), .in_data(in_data), .key_idx(key_idx),
    .key_data(key_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [W-1:0] key_of(input int i);
    logic [63:0] t;
    t = 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15;
    return W'(t ^ 64'h0F1E_2D3C_4B5A_6978);
  endfunction

  always_comb begin
    for (int j = 0; j < UNROLL; j++) key_data[j*W +: W] = key_of(int'(key_idx) + j);
  end

  function automatic logic [W-1:0] enc(input logic [W-1:0] x);
    logic [W-1:0] s, a;
    s = x ^ key_of(0);
    for (int i = 1; i <= ROUNDS; i++) begin
      a = s + key_of(i);
      s = {a[W-ROT-1:0], a[W-1:W-ROT]} ^ key_of(i);
    end
    return s ^ key_of(ROUNDS + 1);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic s, input logic [W-1:0] iv, input logic [W-1:0] pt,
                      input bit noise, output logic [W-1:0] ct, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_iv = iv; in_data = pt;
    @(negedge clk);
    check("R5 ready low after accept", W'(in_ready), W'(0));
    check("R4 key index after accept", W'(key_idx), W'(1));
    in_valid = noise;
    lat = 0;
    do begin
      if (lat > 0 && !out_valid && noise) begin
        in_data = ~in_data; in_sop = ~in_sop; in_iv = in_iv + 1;
      end
      @(negedge clk);
      lat++;
      if (!out_valid && key_idx == IDX_W'(ROUNDS + 1))
        check("R4 final key index", W'(key_idx), W'(ROUNDS + 1));
    end while (!out_valid && lat < 1000);
    in_valid = 1'b0;
    ct = out_data;
    check("R5 ready with output", W'(in_ready), W'(1));
  endtask

  // sop, iv, pt
  localparam logic [2*W:0] VEC [6] = '{
    {1'b1, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF},
    {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    {1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    {1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0123_4567_89AB_CDEF},
    {1'b1, 64'hA5A5_5A5A_A5A5_5A5A, 64'h8000_0000_0000_0001}
  };

  initial begin
    logic [W-1:0] chain, expv, ct, iv, pt;
    logic s;
    int lat;
    chain = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset in_ready", W'(in_ready), W'(1));
    check("R9 reset out_valid", W'(out_valid), W'(0));
    check("R9 reset out_data", out_data, '0);
    check("R4 idle key index", W'(key_idx), W'(0));

    for (int v = 0; v < 6; v++) begin
      s = VEC[v][2*W]; iv = VEC[v][2*W-1:W]; pt = VEC[v][W-1:0];
      expv = enc(pt ^ (s ? iv : chain));
      send(s, iv, pt, 1'b0, ct, lat);
      if (s) check("R1 R3 first block", ct, expv);
      else   check("R2 R10 R3 chained block", ct, expv);
      check("R6 latency", W'(lat), W'(LAT));
      chain = expv;
      @(negedge clk);
      check("R6 single pulse", W'(out_valid), W'(0));
    end

    repeat (5) @(negedge clk);
    check("R7 output held", out_data, chain);

    // R8: inputs toggled while busy
    pt = 64'h0F0F_0F0F_F0F0_F0F0;
    expv = enc(pt ^ chain);
    send(1'b0, 64'h5555_0000_5555_0000, pt, 1'b1, ct, lat);
    check("R8 busy inputs ignored", ct, expv);
    chain = expv;
    begin
      int extra = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      check("R8 no extra output", W'(extra), W'(0));
    end
    pt = 64'h1111_2222_3333_4444;
    expv = enc(pt ^ chain);
    send(1'b0, '0, pt, 1'b0, ct, lat);
    check("R8 chain intact", ct, expv);

    // R9: reset mid-block
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_iv = 64'h7777; in_data = 64'h9999;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid reset in_ready", W'(in_ready), W'(1));
    check("R9 mid reset out_data", out_data, '0);
    check("R9 mid reset key index", W'(key_idx), W'(0));
    pt = 64'hCAFE_F00D_0BAD_BEEF;
    expv = enc(pt);
    send(1'b0, 64'hFFFF, pt, 1'b0, ct, lat);
    check("R9 chain cleared", ct, expv);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule